// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Strobe Cycle Decoder

This block is a synthesizable behavioural model of the device-side control logic of a 4-bit-wide fast-page-mode DRAM. A fast reference clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable), the shared address bus and the write data. The block works out the kind of each memory cycle from the order in which the strobe edges arrive. It then applies the matching rules for the output driver and for latching write data, against a small parameterised word array.

A row strobe fall with the column strobe high opens a page at the row on the address bus. Each column strobe fall inside that page selects a column. Depending on when write enable falls relative to the column strobe, and on the output-enable level at that moment, the access becomes a read, an early write, a late write, a read-modify-write, or a read whose write is refused. A row strobe fall with the column strobe already low is a refresh that takes its row from an internal counter. If the column strobe stayed low from a preceding access, the refresh is hidden and keeps driving the read word. A refresh row strobe held low long enough turns into self refresh. The decoded cycle kind and the row last opened or refreshed are brought out for observation.

The strobes and buses pass through two sampling flops. Two edges that land in the same sample are taken as column-strobe first.

Top module: `fpm_strobe_model`

## Requirements
- R1: After synchronous reset, `dq_oe` is 0, `cyc_type` is 0 (none) and the internal refresh counter is 0, so the first counter-addressed refresh reports row 0.
- R2: Row strobe falling with the column strobe high latches the row from `addr`. A column strobe fall with write enable high latches the column, sets `cyc_type` to 1 (read) and loads the stored word into `dq_out`. `dq_oe` is 1 exactly while output enable is low during that access.
- R3: If write enable is already low in the sample before the column strobe falls, the word on `dq_in` is written at the column strobe fall and `cyc_type` becomes 2 (early write). `dq_oe` stays 0 whatever output enable does until a later column strobe fall starts a read.
- R4: Write enable falling while the column strobe is low and output enable is high writes `dq_in` at that edge, sets `cyc_type` to 3 (late write) and turns the output off. A write-enable fall in the same sample as the column strobe fall counts as this case.
- R5: If output enable was low at some point during the read and is high when write enable falls, the old word is driven first, the new word is then written, and `cyc_type` becomes 4 (read-modify-write).
- R6: A write-enable fall while output enable is low writes nothing. `cyc_type` stays 1 and the output keeps driving the read word.
- R7: A row strobe cycle with no column strobe fall sets `cyc_type` to 5 (row-only refresh) at the row strobe rise, reports the row from `addr` on `dbg_row`, leaves `dq_oe` at 0 and changes no stored word.
- R8: Row strobe falling while the column strobe is low (including a fall in the same sample) with no access pending sets `cyc_type` to 6 (counter refresh). `dbg_row` reports the counter, and `addr` is ignored. The counter then increments, wrapping from 2^ROW_W-1 to 0.
- R9: If the column strobe has stayed low since a page access and the row strobe rises and falls again, `cyc_type` becomes 7 (hidden refresh), the counter row is used and advanced, and `dq_oe`/`dq_out` keep the read word.
- R10: A counter or hidden refresh whose row strobe stays low for SELF_CYCLES samples sets `cyc_type` to 8 (self refresh). A row strobe rise leaves it, and the counter does not move during it.
- R11: A column strobe rise turns `dq_oe` off. Several column strobe cycles under one row strobe low all use the latched row (page mode), and the row strobe rise closes the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data seen on the data pins |
| dq_out | output | DQ_W | Read data the device would drive |
| dq_oe | output | 1 | 1 when the device drives the data pins |
| cyc_type | output | 4 | Decoded cycle kind (codes in R2 to R10) |
| dbg_row | output | ROW_W | Row used by the latest row strobe cycle |

## Verification
Two pairs of decisions can land in one sample. The first is a column strobe fall together with a write-enable fall, which must resolve to a late write. The second is a row strobe fall together with a column strobe fall, which must resolve to a counter refresh. The bench provokes each pair by changing both strobes at the same drive point, so both edges reach the sampling flops together. It judges the result by the reported cycle code, by the counter row on `dbg_row`, and for the write case by reading the location back in a later page.

// File: rtl/fpm_pkg.sv
// Package: shared types of the fast-page-mode strobe model.
// Assumes: 4-bit cycle code on the debug port; values are part of the
// block's observable behaviour and must not be renumbered.
package fpm_pkg;

    typedef enum logic [3:0] {
        CYC_NONE     = 4'd0,
        CYC_READ     = 4'd1,
        CYC_EARLY_WR = 4'd2,
        CYC_LATE_WR  = 4'd3,
        CYC_RMW      = 4'd4,
        CYC_ROW_ONLY = 4'd5,
        CYC_CTR_RF   = 4'd6,
        CYC_HIDDEN   = 4'd7,
        CYC_SELF     = 4'd8
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAGE = 2'd1,
        ST_RFSH = 2'd2,
        ST_SELF = 2'd3
    } phase_e;

endpackage

// File: rtl/sync_pipe.sv
// Module: sync_pipe
// Two-flop sampling pipeline, one chain per bit.
// Assumes: asynchronous pins; every bit gets the same latency so that a
// bus and the strobes that qualify it stay aligned. RST_VAL is the idle
// level loaded by synchronous reset.
module sync_pipe #(
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic st1, st2;
        // two sample stages for bit b
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1 <= RST_VAL[b];
                st2 <= RST_VAL[b];
            end else begin
                st1 <= d_in[b];
                st2 <= st1;
            end
        end
        assign q[b] = st2;
    end

endmodule

// File: rtl/refresh_counter.sv
// Module: refresh_counter
// Internal row counter for counter-addressed refresh.
// Assumes: one increment per refresh request; wraps at 2^ROW_W.
module refresh_counter #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);

    // advance after each counter-addressed refresh
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + ROW_W'(1);
    end

endmodule

// File: rtl/word_store.sv
// Module: word_store
// Small storage array: one synchronous write port, one combinational read.
// Assumes: contents are not reset; reads of unwritten words are undefined.
module word_store #(
    parameter int AW   = 6,
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DQ_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DQ_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DQ_W-1:0] cells [DEPTH];

    // store one word per write request
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/fpm_cycle_decoder.sv
// Module: fpm_cycle_decoder
// Classifies each strobe cycle from the order of sampled edges and applies
// the output-drive and write-latch rules of that cycle kind.
// Assumes: inputs are already sampled (aligned); an edge is a change
// between consecutive samples; edges in the same sample are taken as
// column-strobe first.
module fpm_cycle_decoder
    import fpm_pkg::*;
#(
    parameter int ROW_W       = 3,
    parameter int COL_W       = 3,
    parameter int DQ_W        = 4,
    parameter int SELF_CYCLES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ras_l,
    input  logic                   cas_l,
    input  logic                   we_l,
    input  logic                   oe_l,
    input  logic [ROW_W-1:0]       row_in,
    input  logic [COL_W-1:0]       col_in,
    input  logic [DQ_W-1:0]        din,
    input  logic [DQ_W-1:0]        rd_word,
    input  logic [ROW_W-1:0]       rfsh_row,
    output logic                   wr_en,
    output logic [ROW_W+COL_W-1:0] wr_addr,
    output logic [DQ_W-1:0]        wr_data,
    output logic [ROW_W+COL_W-1:0] rd_addr,
    output logic                   rfsh_inc,
    output logic                   dq_oe,
    output logic [DQ_W-1:0]        dq_out,
    output logic [3:0]             cyc_type,
    output logic [ROW_W-1:0]       dbg_row
);

    localparam int CNT_W = $clog2(SELF_CYCLES + 1);

    logic             ras_p, cas_p, we_p;
    phase_e           st;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             had_cas, acc_live, rd_cyc, oe_seen, drv;
    logic [DQ_W-1:0]  dout;
    cyc_e             typ;
    logic [ROW_W-1:0] dbg_q;
    logic [CNT_W-1:0] self_cnt;

    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic in_page, early_hit, late_new, late_old;

    // edge flags between consecutive samples
    always_comb begin
        ras_fall = ras_p & ~ras_l;
        ras_rise = ~ras_p & ras_l;
        cas_fall = cas_p & ~cas_l;
        cas_rise = ~cas_p & cas_l;
        we_fall  = we_p & ~we_l;
    end

    // write qualification: early, late in the CAS sample, late afterwards
    always_comb begin
        in_page   = (st == ST_PAGE) && !ras_rise;
        early_hit = in_page && cas_fall && !we_l && !we_fall;
        late_new  = in_page && cas_fall && we_fall && oe_l;
        late_old  = in_page && !cas_fall && !cas_l && we_fall && rd_cyc && oe_l;
        wr_en     = early_hit || late_new || late_old;
        wr_addr   = {row_q, (cas_fall ? col_in : col_q)};
        wr_data   = din;
        rd_addr   = {row_q, col_in};
        rfsh_inc  = (st == ST_IDLE) && ras_fall && !cas_l;
    end

    // previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_p <= 1'b1;
            cas_p <= 1'b1;
            we_p  <= 1'b1;
        end else begin
            ras_p <= ras_l;
            cas_p <= cas_l;
            we_p  <= we_l;
        end
    end

    // cycle phase, classification and output-drive state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            row_q    <= '0;
            col_q    <= '0;
            had_cas  <= 1'b0;
            acc_live <= 1'b0;
            rd_cyc   <= 1'b0;
            oe_seen  <= 1'b0;
            drv      <= 1'b0;
            dout     <= '0;
            typ      <= CYC_NONE;
            dbg_q    <= '0;
            self_cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (!cas_l) begin
                            st       <= ST_RFSH;
                            typ      <= acc_live ? CYC_HIDDEN : CYC_CTR_RF;
                            dbg_q    <= rfsh_row;
                            self_cnt <= '0;
                        end else begin
                            st      <= ST_PAGE;
                            row_q   <= row_in;
                            dbg_q   <= row_in;
                            had_cas <= 1'b0;
                        end
                    end
                end
                ST_PAGE: begin
                    if (ras_rise) begin
                        st <= ST_IDLE;
                        if (!had_cas) typ <= CYC_ROW_ONLY;
                    end else if (cas_fall) begin
                        had_cas  <= 1'b1;
                        acc_live <= 1'b1;
                        col_q    <= col_in;
                        if (early_hit) begin
                            typ    <= CYC_EARLY_WR;
                            drv    <= 1'b0;
                            rd_cyc <= 1'b0;
                        end else if (late_new) begin
                            typ    <= CYC_LATE_WR;
                            drv    <= 1'b0;
                            rd_cyc <= 1'b0;
                        end else begin
                            typ     <= CYC_READ;
                            drv     <= 1'b1;
                            dout    <= rd_word;
                            rd_cyc  <= 1'b1;
                            oe_seen <= !oe_l;
                        end
                    end else if (late_old) begin
                        typ    <= oe_seen ? CYC_RMW : CYC_LATE_WR;
                        drv    <= 1'b0;
                        rd_cyc <= 1'b0;
                    end else if (rd_cyc && !oe_l) begin
                        oe_seen <= 1'b1;
                    end
                end
                ST_RFSH: begin
                    if (ras_rise) begin
                        st <= ST_IDLE;
                    end else if (self_cnt == CNT_W'(SELF_CYCLES - 1)) begin
                        st  <= ST_SELF;
                        typ <= CYC_SELF;
                    end else begin
                        self_cnt <= self_cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (ras_rise) st <= ST_IDLE;
                end
            endcase
            if (cas_rise) begin
                drv      <= 1'b0;
                rd_cyc   <= 1'b0;
                acc_live <= 1'b0;
            end
        end
    end

    assign dq_oe    = drv && !oe_l;
    assign dq_out   = dout;
    assign cyc_type = typ;
    assign dbg_row  = dbg_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cyc_type == 4'(CYC_NONE) && !dq_oe));

    // R3
    early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 4'(CYC_EARLY_WR)) |-> !dq_oe);

    // R11
    cas_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_rise |=> !dq_oe);

    // R8
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ras_fall && !cas_l)
            |=> (rfsh_row == ROW_W'($past(rfsh_row) + ROW_W'(1))));

    // R7
    row_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAGE && ras_rise && !had_cas)
            |=> (cyc_type == 4'(CYC_ROW_ONLY) && !dq_oe));

    // R10
    self_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SELF) |-> (cyc_type == 4'(CYC_SELF)));

endmodule

// File: rtl/fpm_strobe_model.sv
// Module: fpm_strobe_model (top)
// Device-side control model of a fast-page-mode DRAM: samples strobes and
// buses, decodes the cycle kind, keeps the refresh row counter and the
// word array. Assumes the reference clock is much faster than the strobes.
module fpm_strobe_model
    import fpm_pkg::*;
#(
    parameter int ROW_W       = 3,
    parameter int COL_W       = 3,
    parameter int DQ_W        = 4,
    parameter int SELF_CYCLES = 64,
    parameter int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [3:0]        cyc_type,
    output logic [ROW_W-1:0]  dbg_row
);

    localparam int AW   = ROW_W + COL_W;
    localparam int BUSW = ADDR_W + DQ_W;

    logic [3:0]        strb_s;
    logic [BUSW-1:0]   bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DQ_W-1:0]   din_s;
    logic              wr_en, rfsh_inc;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DQ_W-1:0]   wr_data, rd_word;
    logic [ROW_W-1:0]  rfsh_row;

    sync_pipe #(.WIDTH(4), .RST_VAL(4'hF)) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({ras_n, cas_n, we_n, oe_n}), .q(strb_s)
    );

    sync_pipe #(.WIDTH(BUSW), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({addr, dq_in}), .q(bus_s)
    );

    assign {addr_s, din_s} = bus_s;

    refresh_counter #(.ROW_W(ROW_W)) u_rfsh (
        .clk(clk), .rst_n(rst_n), .inc(rfsh_inc), .row(rfsh_row)
    );

    word_store #(.AW(AW), .DQ_W(DQ_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_word)
    );

    fpm_cycle_decoder #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .SELF_CYCLES(SELF_CYCLES)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .ras_l(strb_s[3]), .cas_l(strb_s[2]), .we_l(strb_s[1]), .oe_l(strb_s[0]),
        .row_in(addr_s[ROW_W-1:0]), .col_in(addr_s[COL_W-1:0]),
        .din(din_s), .rd_word(rd_word), .rfsh_row(rfsh_row),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rfsh_inc(rfsh_inc), .dq_oe(dq_oe), .dq_out(dq_out),
        .cyc_type(cyc_type), .dbg_row(dbg_row)
    );

endmodule

// File: tb/fpm_strobe_model_tb.sv
// Scoreboard bench: the driver pushes expected port values, the monitor
// pops them and compares against the live outputs.
module fpm_strobe_model_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SELF_N     = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       dq_oe;
    logic [3:0] cyc_type;
    logic [2:0] dbg_row;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int ctr_model = 0;

    typedef struct {
        string      tag;
        logic       oe;
        logic [3:0] dat;
        logic [3:0] typ;
        logic [2:0] row;
        bit         use_dat;
        bit         use_row;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpm_strobe_model #(.SELF_CYCLES(SELF_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cyc_type(cyc_type), .dbg_row(dbg_row)
    );

    // wait past the two sample flops and the decode register
    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_now(string tag, logic e_oe, logic [3:0] e_dat,
                              logic [3:0] e_typ, logic [2:0] e_row,
                              bit use_dat, bit use_row);
        exp_t e;
        e.tag = tag; e.oe = e_oe; e.dat = e_dat; e.typ = e_typ; e.row = e_row;
        e.use_dat = use_dat; e.use_row = use_row;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (dq_oe !== e.oe || cyc_type !== e.typ ||
                    (e.use_dat && dq_out !== e.dat) ||
                    (e.use_row && dbg_row !== e.row)) begin
                    bad++;
                    $display("FAIL %s: got oe=%0b dat=%h typ=%0d row=%0d exp oe=%0b dat=%h typ=%0d row=%0d",
                             e.tag, dq_oe, dq_out, cyc_type, dbg_row,
                             e.oe, e.dat, e.typ, e.row);
                end
            end
        end
    end

    // open a page at row r
    task automatic open_row(logic [2:0] r);
        addr = r; ras_n = 0; settle();
    endtask

    task automatic close_all();
        cas_n = 1; we_n = 1; oe_n = 1; settle();
        ras_n = 1; settle();
    endtask

    // read a word back in its own page and check it
    task automatic read_back(string tag, logic [2:0] r, logic [2:0] c, logic [3:0] v);
        open_row(r);
        oe_n = 0; addr = c; settle();
        cas_n = 0; settle();
        expect_now(tag, 1'b1, v, 4'd1, r, 1'b1, 1'b1);
        close_all();
    endtask

    // counter refresh with CAS before RAS
    task automatic ctr_refresh(string tag, bit same);
        if (same) begin
            addr = 3'd6; cas_n = 0; ras_n = 0; settle();
        end else begin
            cas_n = 0; settle();
            addr = 3'd6; ras_n = 0; settle();
        end
        expect_now(tag, 1'b0, 4'h0, 4'd6, 3'(ctr_model), 1'b0, 1'b1);
        ctr_model = (ctr_model + 1) % 8;
        ras_n = 1; settle();
        cas_n = 1; settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        expect_now("R1 reset", 1'b0, 4'h0, 4'd0, 3'd0, 1'b0, 1'b0);
        rst_n = 1; settle();
        expect_now("R1 idle after reset", 1'b0, 4'h0, 4'd0, 3'd0, 1'b0, 1'b0);

        // R3 / R11: early writes, two columns in one page, OE held low
        open_row(3'd1);
        oe_n = 0; we_n = 0; dq_in = 4'hA; addr = 3'd2; settle();
        cas_n = 0; settle();
        expect_now("R3 early write quiet", 1'b0, 4'h0, 4'd2, 3'd1, 1'b0, 1'b1);
        cas_n = 1; settle();
        dq_in = 4'hB; addr = 3'd3; settle();
        cas_n = 0; settle();
        expect_now("R3 R11 page second early write", 1'b0, 4'h0, 4'd2, 3'd1, 1'b0, 1'b1);
        close_all();

        // R2 / R11: page read of both columns, OE gating, CAS rise
        open_row(3'd1);
        oe_n = 0; addr = 3'd2; settle();
        cas_n = 0; settle();
        expect_now("R2 read col2", 1'b1, 4'hA, 4'd1, 3'd1, 1'b1, 1'b1);
        oe_n = 1; settle();
        expect_now("R2 oe high stops drive", 1'b0, 4'hA, 4'd1, 3'd1, 1'b0, 1'b1);
        oe_n = 0; settle();
        cas_n = 1; settle();
        expect_now("R11 cas rise off", 1'b0, 4'h0, 4'd1, 3'd1, 1'b0, 1'b1);
        addr = 3'd3; settle();
        cas_n = 0; settle();
        expect_now("R11 page read col3", 1'b1, 4'hB, 4'd1, 3'd1, 1'b1, 1'b1);
        close_all();

        // R4: late write with OE high
        open_row(3'd1);
        addr = 3'd2; settle();
        cas_n = 0; settle();
        dq_in = 4'hC; we_n = 0; settle();
        expect_now("R4 late write", 1'b0, 4'h0, 4'd3, 3'd1, 1'b0, 1'b1);
        close_all();
        read_back("R4 late readback", 3'd1, 3'd2, 4'hC);

        // R4: WE and CAS fall in the same sample -> late write
        open_row(3'd1);
        addr = 3'd3; dq_in = 4'hD; settle();
        cas_n = 0; we_n = 0; settle();
        expect_now("R4 same-sample late", 1'b0, 4'h0, 4'd3, 3'd1, 1'b0, 1'b1);
        close_all();
        read_back("R4 same-sample readback", 3'd1, 3'd3, 4'hD);

        // R5: read-modify-write
        open_row(3'd1);
        oe_n = 0; addr = 3'd2; settle();
        cas_n = 0; settle();
        expect_now("R5 rmw read phase", 1'b1, 4'hC, 4'd1, 3'd1, 1'b1, 1'b1);
        oe_n = 1; settle();
        dq_in = 4'hE; we_n = 0; settle();
        expect_now("R5 rmw write phase", 1'b0, 4'h0, 4'd4, 3'd1, 1'b0, 1'b1);
        close_all();
        read_back("R5 rmw readback", 3'd1, 3'd2, 4'hE);

        // R6: WE falls while OE low -> no write, keeps driving
        open_row(3'd1);
        oe_n = 0; addr = 3'd3; settle();
        cas_n = 0; settle();
        dq_in = 4'h5; we_n = 0; settle();
        expect_now("R6 refused write drives", 1'b1, 4'hD, 4'd1, 3'd1, 1'b1, 1'b1);
        close_all();
        read_back("R6 word unchanged", 3'd1, 3'd3, 4'hD);

        // R7: row-only refresh
        open_row(3'd5);
        oe_n = 0; dq_in = 4'h7; settle();
        ras_n = 1; settle();
        expect_now("R7 row-only refresh", 1'b0, 4'h0, 4'd5, 3'd5, 1'b0, 1'b1);
        oe_n = 1; settle();
        read_back("R7 store untouched", 3'd1, 3'd2, 4'hE);

        // R8 / R1: counter refresh starts at 0, same-sample variant
        ctr_refresh("R8 R1 counter refresh row0", 1'b0);
        ctr_refresh("R8 same-sample counter refresh", 1'b1);

        // R9: hidden refresh after a read
        open_row(3'd1);
        oe_n = 0; addr = 3'd2; settle();
        cas_n = 0; settle();
        ras_n = 1; settle();
        expect_now("R9 output held after ras rise", 1'b1, 4'hE, 4'd1, 3'd1, 1'b1, 1'b1);
        addr = 3'd4; ras_n = 0; settle();
        expect_now("R9 hidden refresh", 1'b1, 4'hE, 4'd7, 3'(ctr_model), 1'b1, 1'b1);
        ctr_model = (ctr_model + 1) % 8;
        ras_n = 1; settle();
        cas_n = 1; oe_n = 1; settle();

        // R10: self refresh after a long counter refresh
        cas_n = 0; settle();
        ras_n = 0; settle();
        expect_now("R10 before threshold", 1'b0, 4'h0, 4'd6, 3'(ctr_model), 1'b0, 1'b1);
        ctr_model = (ctr_model + 1) % 8;
        repeat (SELF_N + 4) @(posedge clk);
        @(negedge clk);
        expect_now("R10 self refresh", 1'b0, 4'h0, 4'd8, 3'd0, 1'b0, 1'b0);
        ras_n = 1; settle();
        cas_n = 1; settle();
        expect_now("R10 exit keeps code", 1'b0, 4'h0, 4'd8, 3'd0, 1'b0, 1'b0);

        // R8: counter wrap
        for (int k = 0; k < 5; k++) ctr_refresh("R8 counter walk/wrap", 1'b0);
        read_back("R10 data retained", 3'd1, 3'd3, 4'hD);

        #(CLK_PERIOD);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule